// File: doc/BRIEF.md
# Raster Timing Generator with Atomic Register Commit

This block produces the raster timing for one display stream. Two counters walk the pixels of each line and the lines of each frame. From them it drives horizontal and vertical sync, an active-video qualifier and a vertical-blank flag. Inside blanking it also fires three one-cycle global sync pulses: a startup pulse, an update pulse and a ready pulse. Each pulse sits at its own programmed line and pixel and has no link to the vsync edges.

All programmable state sits behind a two-copy register set: the raster geometry, the three pulse positions and a surface base address. A host writes the pending copy through a plain write port, one field per cycle, at any point in the frame. The port accepts a write every cycle and never applies back-pressure. The active copy drives the logic. It takes the whole pending copy in the single clock edge that ends the update pulse. A burst of host writes between two update pulses therefore behaves like a mailbox: only the last value of each field takes effect.

The host sees three status outputs. A sticky event flag rises on every update pulse and serves as the frame or flip-complete notice. A pending flag shows that a commit is still outstanding. A configuration error flag shows that pulse positions are misplaced or collide.

Top module: `dtg_top`

## Requirements
- R1: While reset is asserted, every sync, blank, active-video and pulse output is 0, `surf_addr` is 0, `pend_valid` is 0 and `upd_irq` is 0. Both register copies reset to zero. The outputs stay inactive until the counters first wrap to line 0, pixel 0.
- R2: A frame is (v_last+1) lines of (h_last+1) pixels. `active_video` is 1 when pixel < h_act and line < v_act. `vblank` is 1 when line >= v_act.
- R3: `hsync` is 1 for pixels in [h_ss, h_se). `vsync` is 1 for lines in [v_ss, v_se).
- R4: Each global pulse is high for exactly one cycle per frame, at its programmed line and pixel. Its position does not depend on the vsync settings.
- R5: A startup or ready pulse whose position lies outside blanking (line < v_act, line > v_last or pixel > h_last) is suppressed, and `cfg_err` is 1. A misplaced update pulse raises `cfg_err` but still fires, so that the host can always commit a fix.
- R6: No two pulses are ever high in the same cycle. When positions are equal, priority runs update, then startup, then ready; each lower-priority pulse is suppressed and `cfg_err` is 1.
- R7: Register addresses on `cfg_addr` are: 0 h_last, 1 h_act, 2 h_ss, 3 h_se, 4 v_last, 5 v_act, 6 v_ss, 7 v_se, 8/9 startup line/pixel, 10/11 update line/pixel, 12/13 ready line/pixel, 14 surface address. Data is taken from the low bits of `cfg_wdata`. A write changes only the pending copy. The active copy, and so `surf_addr`, changes only on the clock edge that ends an update pulse, and every field changes in that same edge.
- R8: When a field is written several times between two update pulses, only the last value becomes active.
- R9: The geometry fields are double buffered like the rest of the register set. A change to h_last written early in a frame alters line length only from the update pulse onward.
- R10: `pend_valid` goes to 1 in the cycle after a write. It goes to 0 after an update pulse in which no write occurred.
- R11: `upd_irq` goes to 1 in the cycle after an update pulse. A pulse on `irq_clr` clears it, but a new update pulse in the same cycle takes precedence.
- R12: With the all-zero registers left by reset, every cycle is a one-pixel frame in blanking. The update pulse therefore fires on every cycle once the counters are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host write strobe for the pending copy |
| cfg_addr | input | 4 | Register index (map in R7) |
| cfg_wdata | input | 32 | Write data |
| irq_clr | input | 1 | Clears the update event flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| active_video | output | 1 | Pixel lies in the visible area |
| vblank | output | 1 | Line lies in vertical blanking |
| gs_startup | output | 1 | Startup global sync pulse |
| gs_update | output | 1 | Update global sync pulse (commit point) |
| gs_ready | output | 1 | Ready global sync pulse |
| surf_addr | output | 32 | Active surface base address |
| pend_valid | output | 1 | Pending copy holds an uncommitted write |
| upd_irq | output | 1 | Sticky update event toward the host |
| cfg_err | output | 1 | Active pulse positions misplaced or colliding |

## Verification
A corrupted active copy shows up at the ports within one frame: the frame length, the active-video count or the pulse positions drift from the programmed geometry. A commit that lands at the wrong moment shows up as a surface address that changes before the update pulse. It also shows up as a frame whose length mixes old and new line lengths at a point other than the update position. A wrong pending flag or event flag is visible in the cycle right after the write or the pulse. A faulty collision or blanking check becomes visible on the next frame, as a missing pulse, a second pulse in one cycle or a wrong `cfg_err`.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  parameter int unsigned POS_W  = 12;
  parameter int unsigned SURF_W = 32;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned ADDR_W = 4;
  parameter int unsigned NUM_GS = 3;

  localparam int IDX_START = 0;
  localparam int IDX_UPD   = 1;
  localparam int IDX_READY = 2;

  typedef struct packed {
    logic [POS_W-1:0] h_last;
    logic [POS_W-1:0] h_act;
    logic [POS_W-1:0] h_ss;
    logic [POS_W-1:0] h_se;
    logic [POS_W-1:0] v_last;
    logic [POS_W-1:0] v_act;
    logic [POS_W-1:0] v_ss;
    logic [POS_W-1:0] v_se;
  } raster_t;

  typedef struct packed {
    logic [POS_W-1:0] line;
    logic [POS_W-1:0] pix;
  } gpos_t;

  typedef struct packed {
    raster_t                tm;
    gpos_t [NUM_GS-1:0]     gs;
    logic  [SURF_W-1:0]     surf;
  } dcfg_t;

  typedef enum logic [ADDR_W-1:0] {
    RA_HLAST = 4'd0,  RA_HACT = 4'd1,  RA_HSS = 4'd2,  RA_HSE = 4'd3,
    RA_VLAST = 4'd4,  RA_VACT = 4'd5,  RA_VSS = 4'd6,  RA_VSE = 4'd7,
    RA_STL   = 4'd8,  RA_STP  = 4'd9,  RA_UPL = 4'd10, RA_UPP = 4'd11,
    RA_RDL   = 4'd12, RA_RDP  = 4'd13, RA_SURF = 4'd14
  } reg_addr_e;

  // Larger value wins a position collision.
  function automatic int gs_prio(int idx);
    if (idx == IDX_UPD)   return 2;
    if (idx == IDX_START) return 1;
    return 0;
  endfunction

endpackage

// File: rtl/dtg_shadow_regs.sv
module dtg_shadow_regs
  import dtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic              pend_valid,
  output dcfg_t             act
);

  localparam int unsigned SW = (SURF_W < DATA_W) ? SURF_W : DATA_W;

  dcfg_t pend_q;
  dcfg_t act_q;
  logic  pv_q;
  logic [POS_W-1:0] wpos;

  assign wpos = wr_data[POS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_HLAST: pend_q.tm.h_last <= wpos;
        RA_HACT:  pend_q.tm.h_act  <= wpos;
        RA_HSS:   pend_q.tm.h_ss   <= wpos;
        RA_HSE:   pend_q.tm.h_se   <= wpos;
        RA_VLAST: pend_q.tm.v_last <= wpos;
        RA_VACT:  pend_q.tm.v_act  <= wpos;
        RA_VSS:   pend_q.tm.v_ss   <= wpos;
        RA_VSE:   pend_q.tm.v_se   <= wpos;
        RA_STL:   pend_q.gs[IDX_START].line <= wpos;
        RA_STP:   pend_q.gs[IDX_START].pix  <= wpos;
        RA_UPL:   pend_q.gs[IDX_UPD].line   <= wpos;
        RA_UPP:   pend_q.gs[IDX_UPD].pix    <= wpos;
        RA_RDL:   pend_q.gs[IDX_READY].line <= wpos;
        RA_RDP:   pend_q.gs[IDX_READY].pix  <= wpos;
        RA_SURF:  pend_q.surf <= SURF_W'(wr_data[SW-1:0]);
        default:  pend_q <= pend_q;
      endcase
    end
  end

  // Whole-set copy in one edge: the commit point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pv_q <= 1'b0;
    else if (wr_en) pv_q <= 1'b1;
    else if (load)  pv_q <= 1'b0;
  end

  assign act        = act_q;
  assign pend_valid = pv_q;

  // R7: active copy holds between commits
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));
  // R7: a commit transfers the whole pending set
  a_r7_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_q == $past(pend_q)));
  // R10: a write leaves a commit outstanding
  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_valid);
  // R10: a commit with no concurrent write clears the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> !pend_valid);

endmodule

// File: rtl/dtg_raster.sv
module dtg_raster
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  raster_t          tm,
  output logic [POS_W-1:0] hcnt,
  output logic [POS_W-1:0] vcnt,
  output logic             started,
  output logic             hsync,
  output logic             vsync,
  output logic             active_video,
  output logic             vblank
);

  logic [POS_W-1:0] hcnt_q, vcnt_q;
  logic             run_q;
  logic             h_end, v_end;

  assign h_end = (hcnt_q >= tm.h_last);
  assign v_end = (vcnt_q >= tm.v_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
      run_q  <= 1'b0;
    end else if (h_end) begin
      hcnt_q <= '0;
      if (v_end) begin
        vcnt_q <= '0;
        run_q  <= 1'b1;
      end else begin
        vcnt_q <= vcnt_q + 1'b1;
      end
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign hcnt    = hcnt_q;
  assign vcnt    = vcnt_q;
  assign started = run_q;

  assign hsync        = run_q && (hcnt_q >= tm.h_ss) && (hcnt_q < tm.h_se);
  assign vsync        = run_q && (vcnt_q >= tm.v_ss) && (vcnt_q < tm.v_se);
  assign active_video = run_q && (hcnt_q < tm.h_act) && (vcnt_q < tm.v_act);
  assign vblank       = run_q && (vcnt_q >= tm.v_act);

  // R2: after the last pixel of the last line the raster restarts at the origin
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (h_end && v_end) |=> (hcnt_q == '0 && vcnt_q == '0 && run_q));

endmodule

// File: rtl/dtg_gsync.sv
module dtg_gsync
  import dtg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  raster_t            tm,
  input  gpos_t [NUM_GS-1:0] gs,
  input  logic [POS_W-1:0]   hcnt,
  input  logic [POS_W-1:0]   vcnt,
  input  logic               started,
  output logic [NUM_GS-1:0]  pulse,
  output logic               cfg_err
);

  logic [NUM_GS-1:0] outside, beaten, hit;

  for (genvar i = 0; i < NUM_GS; i++) begin : g_pulse
    logic [NUM_GS-1:0] loses;
    for (genvar j = 0; j < NUM_GS; j++) begin : g_cmp
      if (j != i && gs_prio(j) > gs_prio(i)) begin : g_hi
        assign loses[j] = (gs[j] == gs[i]);
      end else begin : g_lo
        assign loses[j] = 1'b0;
      end
    end
    assign beaten[i]  = |loses;
    assign outside[i] = (gs[i].line < tm.v_act) || (gs[i].line > tm.v_last) ||
                        (gs[i].pix > tm.h_last);
    assign hit[i]     = started && (vcnt == gs[i].line) && (hcnt == gs[i].pix);
    if (i == IDX_UPD) begin : g_commit
      assign pulse[i] = hit[i];
    end else begin : g_gated
      assign pulse[i] = hit[i] && !outside[i] && !beaten[i];
    end
  end

  assign cfg_err = (|outside) || (|beaten);

  // R6: pulses never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pulse) <= 1);
  // R5: startup and ready only inside vertical blanking
  a_r5_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse[IDX_START] || pulse[IDX_READY]) |-> (vcnt >= tm.v_act && vcnt <= tm.v_last));
  // R4: a pulse lasts a single cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse[IDX_START] && tm.h_last != '0) |=> !pulse[IDX_START]);

endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              irq_clr,
  output logic              hsync,
  output logic              vsync,
  output logic              active_video,
  output logic              vblank,
  output logic              gs_startup,
  output logic              gs_update,
  output logic              gs_ready,
  output logic [SURF_W-1:0] surf_addr,
  output logic              pend_valid,
  output logic              upd_irq,
  output logic              cfg_err
);

  dcfg_t             act;
  logic [POS_W-1:0]  hcnt, vcnt;
  logic              started;
  logic [NUM_GS-1:0] pulse;
  logic              irq_q;

  dtg_shadow_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .load       (pulse[IDX_UPD]),
    .pend_valid (pend_valid),
    .act        (act)
  );

  dtg_raster u_raster (
    .clk          (clk),
    .rst_n        (rst_n),
    .tm           (act.tm),
    .hcnt         (hcnt),
    .vcnt         (vcnt),
    .started      (started),
    .hsync        (hsync),
    .vsync        (vsync),
    .active_video (active_video),
    .vblank       (vblank)
  );

  dtg_gsync u_gsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tm      (act.tm),
    .gs      (act.gs),
    .hcnt    (hcnt),
    .vcnt    (vcnt),
    .started (started),
    .pulse   (pulse),
    .cfg_err (cfg_err)
  );

  assign gs_startup = pulse[IDX_START];
  assign gs_update  = pulse[IDX_UPD];
  assign gs_ready   = pulse[IDX_READY];
  assign surf_addr  = act.surf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (gs_update) irq_q <= 1'b1;
    else if (irq_clr)   irq_q <= 1'b0;
  end
  assign upd_irq = irq_q;

  // R1: nothing toggles before the first frame boundary
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !(hsync || vsync || active_video || vblank || (|pulse)));
  // R11: update pulse raises the host event, even against a clear
  a_r11_event: assert property (@(posedge clk) disable iff (!rst_n)
    gs_update |=> upd_irq);

endmodule

// File: tb/dtg_top_bench.sv
module dtg_top_bench;
  import dtg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic irq_clr = 1'b0;
  logic hsync, vsync, active_video, vblank, gs_startup, gs_update, gs_ready;
  logic [SURF_W-1:0] surf_addr;
  logic pend_valid, upd_irq, cfg_err;

  always #5 clk = ~clk;

  dtg_top u_dtg_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_clr(irq_clr), .hsync(hsync), .vsync(vsync),
    .active_video(active_video), .vblank(vblank), .gs_startup(gs_startup),
    .gs_update(gs_update), .gs_ready(gs_ready), .surf_addr(surf_addr),
    .pend_valid(pend_valid), .upd_irq(upd_irq), .cfg_err(cfg_err)
  );

  int n_checks = 0;
  int n_errs   = 0;

  task automatic chk(string req, longint act_v, longint exp_v);
    n_checks++;
    if (act_v != exp_v) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // ---------------- frame monitor ----------------
  int pos = 0, fr_cnt = 0;
  int c_de, c_hs, c_vs, c_vb, c_st, c_up, c_rd, c_ovl, c_out;
  int p_st, p_up, p_rd, p_vsr;
  int l_len, l_de, l_hs, l_vs, l_vb, l_st, l_up, l_rd, l_ovl, l_out;
  int l_pst, l_pup, l_prd, l_pvsr;
  logic prev_vb = 1'b0, prev_vs = 1'b0;

  // ---------------- scoreboard ----------------
  logic [SURF_W-1:0] exp_q[$];
  logic up_seen = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pos = 0; prev_vb = 1'b0; prev_vs = 1'b0; up_seen = 1'b0;
      c_de = 0; c_hs = 0; c_vs = 0; c_vb = 0; c_st = 0; c_up = 0; c_rd = 0;
      c_ovl = 0; c_out = 0;
    end else begin
      if (up_seen && exp_q.size() > 0) begin
        logic [SURF_W-1:0] e;
        e = exp_q.pop_front();
        chk("R8 surface after commit", surf_addr, e);
      end
      up_seen = gs_update;
      if (prev_vb && !vblank) begin
        l_len = pos; l_de = c_de; l_hs = c_hs; l_vs = c_vs; l_vb = c_vb;
        l_st = c_st; l_up = c_up; l_rd = c_rd; l_ovl = c_ovl; l_out = c_out;
        l_pst = p_st; l_pup = p_up; l_prd = p_rd; l_pvsr = p_vsr;
        fr_cnt++;
        pos = 0; c_de = 0; c_hs = 0; c_vs = 0; c_vb = 0; c_st = 0; c_up = 0;
        c_rd = 0; c_ovl = 0; c_out = 0;
      end
      c_de += int'(active_video); c_hs += int'(hsync);
      c_vs += int'(vsync);        c_vb += int'(vblank);
      if (gs_startup) begin c_st++; p_st = pos; if (!vblank) c_out++; end
      if (gs_update)  begin c_up++; p_up = pos; end
      if (gs_ready)   begin c_rd++; p_rd = pos; if (!vblank) c_out++; end
      if (int'(gs_startup) + int'(gs_update) + int'(gs_ready) > 1) c_ovl++;
      if (vsync && !prev_vs) p_vsr = pos;
      prev_vb = vblank; prev_vs = vsync;
      pos++;
    end
  end

  task automatic wr(reg_addr_e a, int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DATA_W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_frame();
    int f;
    f = fr_cnt;
    while (fr_cnt == f) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(10 * 150000);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  // ---------------- driver ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {hsync, vsync, active_video, vblank,
        gs_startup, gs_update, gs_ready, pend_valid, upd_irq}, 0);
    chk("R1 surface in reset", surf_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 zero config update fires", {gs_update, vblank}, 2'b11);
    @(negedge clk);
    chk("R12 zero config update each cycle", gs_update, 1);

    // bring-up: 20 px/line, 10 lines
    wr(RA_HLAST, 19); wr(RA_HACT, 12); wr(RA_HSS, 14); wr(RA_HSE, 16);
    wr(RA_VLAST, 9);  wr(RA_VACT, 6);  wr(RA_VSS, 7);  wr(RA_VSE, 8);
    wr(RA_STL, 6); wr(RA_STP, 2); wr(RA_UPL, 7); wr(RA_UPP, 5);
    wr(RA_RDL, 8); wr(RA_RDP, 10); wr(RA_SURF, 32'h1000);
    while (pend_valid) @(negedge clk);
    wait_frame(); wait_frame(); wait_frame();

    chk("R2 frame length", l_len, 200);
    chk("R2 active video count", l_de, 72);
    chk("R2 vblank count", l_vb, 80);
    chk("R3 hsync count", l_hs, 20);
    chk("R3 vsync count", l_vs, 20);
    chk("R3 vsync rise position", l_pvsr, 140);
    chk("R4 pulse counts", l_st * 100 + l_up * 10 + l_rd, 111);
    chk("R4 startup position", l_pst, 122);
    chk("R4 update position", l_pup, 145);
    chk("R4 ready position", l_prd, 170);
    chk("R5 pulses in blank", l_out, 0);
    chk("R6 no overlap", l_ovl, 0);
    chk("R6 no cfg error", cfg_err, 0);
    chk("R7 initial surface", surf_addr, 32'h1000);

    // mailbox: three writes, last wins
    wr(RA_SURF, 32'h2000);
    chk("R10 pending after write", pend_valid, 1);
    wr(RA_SURF, 32'h3000);
    wr(RA_SURF, 32'h4000);
    exp_q.push_back(32'h4000);
    chk("R7 surface unchanged before commit", surf_addr, 32'h1000);
    wait_frame();
    chk("R10 pending cleared by commit", pend_valid, 0);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    wr(RA_SURF, 32'h5000);
    wr(RA_SURF, 32'h6000);
    exp_q.push_back(32'h6000);
    wait_frame();
    chk("R8 second commit drained", exp_q.size(), 0);
    chk("R8 surface after second commit", surf_addr, 32'h6000);

    // event flag
    chk("R11 event set", upd_irq, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R11 event cleared", upd_irq, 0);
    while (!gs_update) @(negedge clk);
    @(negedge clk);
    chk("R11 event after update", upd_irq, 1);

    // geometry change takes effect at the update pulse
    wait_frame();
    wr(RA_HLAST, 24);
    wait_frame();
    chk("R9 mixed frame length", l_len, 215);
    wait_frame();
    chk("R9 new frame length", l_len, 250);
    chk("R9 update position on new geometry", l_pup, 180);

    // collision: ready placed on startup
    wr(RA_RDL, 6); wr(RA_RDP, 2);
    wait_frame();
    chk("R6 collision flagged", cfg_err, 1);
    wait_frame();
    chk("R6 ready suppressed", l_rd, 0);
    chk("R6 startup kept", l_st, 1);
    chk("R6 no overlap on collision", l_ovl, 0);

    // out of blank: startup on an active line
    wr(RA_RDL, 8); wr(RA_RDP, 10); wr(RA_STL, 2);
    wait_frame();
    wait_frame();
    chk("R5 out of blank flagged", cfg_err, 1);
    chk("R5 startup suppressed", l_st, 0);
    chk("R5 update still fires", l_up, 1);
    chk("R5 ready fires", l_rd, 1);
    wr(RA_STL, 6);
    wait_frame();
    wait_frame();
    chk("R5 error cleared", cfg_err, 0);
    chk("R4 startup restored", l_st, 1);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule